// File: doc/BRIEF.md
# SDRAM Automatic Power-Down Controller

This block owns the SDRAM clock-enable line for automatic power-down. It watches three conditions in the memory-clock domain: the command FIFO is empty, the last inter-command delay has expired, and the read-data FIFO has drained. When all three hold, the interface is idle. Once it has been idle for a programmed number of consecutive cycles, the block drops clock-enable and the memory enters power-down.

The block wakes only when the command FIFO becomes non-empty. It then raises clock-enable again and holds off command issue for a programmed exit time. A power-down flag mirrors the low state of clock-enable for the rest of the controller. An enable input and a period of zero each turn automatic entry off.

All three outputs are registered on the falling edge of the memory clock, like the other command control outputs. The decision logic runs on the rising edge.

Top module: `pdn_ctrl`

## Requirements
- R1: While reset is high, and at the first falling edge after it, cke is 1, pwr_down is 0 and issue_hold is 0.
- R2: A rising edge is idle when cmd_fifo_empty=1, cmd_delay_done=1 and rdata_fifo_empty=1, with pd_enable=1 and pd_period=P>0. After P consecutive idle rising edges, cke goes to 0 at the falling edge that follows the P-th of them.
- R3: A rising edge at which any one of the three idle inputs is 0 restarts the idle count from zero. Power-down then needs P fresh consecutive idle edges.
- R4: With pd_enable=0 or pd_period=0, cke never falls. Once enable is set, entry again takes P idle edges.
- R5: In power-down, a rising edge with cmd_fifo_empty=0 makes cke 1 at the next falling edge.
- R6: When cke rises on wake-up with txp_cycles=X, issue_hold is 1 for exactly X cycles, starting at that same falling edge. If X=0, issue_hold stays 0.
- R7: pwr_down is always the inverse of cke.
- R8: While cmd_fifo_empty=0, cke stays 1.
- R9: In power-down, changes on cmd_delay_done or rdata_fifo_empty do not wake the memory; cke stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_enable | input | 1 | Allows automatic power-down entry |
| cmd_fifo_empty | input | 1 | Command FIFO holds nothing |
| cmd_delay_done | input | 1 | Last inter-command delay has expired |
| rdata_fifo_empty | input | 1 | Read-data FIFO has drained |
| pd_period | input | PD_W (8) | Idle cycles before entry; 0 disables entry |
| txp_cycles | input | XP_W (4) | Power-down exit time in cycles |
| cke | output | 1 | Clock-enable to the memory, falling-edge registered |
| pwr_down | output | 1 | High while the memory is in power-down |
| issue_hold | output | 1 | Blocks command issue during the exit time |

## Verification
A wrong idle count shows up as a clock-enable drop one or more cycles early or late relative to the P-th idle edge. It can also show as a drop after an interrupted idle stretch, visible at the first falling edge where the wrong count expires. A stuck or miscounted exit timer shows up as issue_hold lasting a different number of cycles than tXP, seen within tXP+1 cycles of wake-up. A state that reacts to the wrong input shows up as cke rising, or failing to rise, at the falling edge after that input changes.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

  typedef enum logic [1:0] {
    PDN_RUN  = 2'd0,
    PDN_DOWN = 2'd1,
    PDN_EXIT = 2'd2
  } pdn_state_t;

  localparam int PDN_OUT_W = 3;

endpackage

// File: rtl/pdn_idle_timer.sv
module pdn_idle_timer #(
  parameter int PD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            count_en,
  input  logic            idle,
  input  logic [PD_W-1:0] period,
  output logic            expire
);

  localparam logic [PD_W-1:0] ONE = PD_W'(1);

  logic [PD_W-1:0] cnt;
  logic            armed;

  // counting only makes sense with a non-zero period
  assign armed  = count_en && (period != '0);
  assign expire = armed && idle && (cnt == period - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!armed || !idle || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/pdn_exit_timer.sv
module pdn_exit_timer #(
  parameter int XP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [XP_W-1:0] txp,
  output logic            done
);

  localparam logic [XP_W-1:0] ONE = XP_W'(1);

  logic [XP_W-1:0] cnt;

  assign done = run && (cnt == txp - ONE);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/pdn_edge_out.sv
module pdn_edge_out #(
  parameter int              W        = 3,
  parameter logic [W-1:0]    RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // one flop per output bit, launched on the falling edge
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(negedge clk) begin
      if (rst) q[i] <= RST_VAL[i];
      else     q[i] <= d[i];
    end
  end

endmodule

// File: rtl/pdn_ctrl.sv
module pdn_ctrl
  import pdn_pkg::*;
#(
  parameter int PD_W = 8,
  parameter int XP_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_enable,
  input  logic            cmd_fifo_empty,
  input  logic            cmd_delay_done,
  input  logic            rdata_fifo_empty,
  input  logic [PD_W-1:0] pd_period,
  input  logic [XP_W-1:0] txp_cycles,
  output logic            cke,
  output logic            pwr_down,
  output logic            issue_hold
);

  // output vector order: {issue_hold, pwr_down, cke}
  localparam logic [PDN_OUT_W-1:0] OUT_RST = 3'b001;

  pdn_state_t state, state_nx;
  logic       idle;
  logic       idle_expire;
  logic       exit_done;
  logic       wake;
  logic [PDN_OUT_W-1:0] out_d, out_q;

  assign idle = cmd_fifo_empty && cmd_delay_done && rdata_fifo_empty;
  assign wake = !cmd_fifo_empty;

  pdn_idle_timer #(.PD_W(PD_W)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .count_en (pd_enable && (state == PDN_RUN)),
    .idle     (idle),
    .period   (pd_period),
    .expire   (idle_expire)
  );

  pdn_exit_timer #(.XP_W(XP_W)) u_exit (
    .clk  (clk),
    .rst  (rst),
    .run  (state == PDN_EXIT),
    .txp  (txp_cycles),
    .done (exit_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      PDN_RUN:  if (idle_expire) state_nx = PDN_DOWN;
      PDN_DOWN: if (wake) state_nx = (txp_cycles == '0) ? PDN_RUN : PDN_EXIT;
      PDN_EXIT: if (exit_done) state_nx = PDN_RUN;
      default:  state_nx = PDN_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= PDN_RUN;
    else     state <= state_nx;
  end

  assign out_d = {(state == PDN_EXIT), (state == PDN_DOWN), (state != PDN_DOWN)};

  pdn_edge_out #(.W(PDN_OUT_W), .RST_VAL(OUT_RST)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (out_d),
    .q   (out_q)
  );

  assign cke        = out_q[0];
  assign pwr_down   = out_q[1];
  assign issue_hold = out_q[2];

endmodule

// File: rtl/pdn_ctrl_chk.sv
module pdn_ctrl_chk #(
  parameter int PD_W = 8,
  parameter int XP_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            pd_enable,
  input logic            cmd_fifo_empty,
  input logic [PD_W-1:0] pd_period,
  input logic [XP_W-1:0] txp_cycles,
  input logic            cke,
  input logic            pwr_down,
  input logic            issue_hold
);

  // R7: flag mirrors clock-enable
  p_flag_mirror_r7: assert property (@(posedge clk) disable iff (rst)
    pwr_down == !cke);

  // R5: wake-up at the next falling edge
  p_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (!cke && !cmd_fifo_empty) |=> cke);

  // R8: pending commands keep the memory awake
  p_busy_awake_r8: assert property (@(posedge clk) disable iff (rst)
    (cke && !cmd_fifo_empty) |=> cke);

  // R4: disabled entry
  p_no_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (cke && (!pd_enable || pd_period == '0)) |=> cke);

  // R6: exit hold starts with the rise of cke
  p_hold_start_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke) && $past(txp_cycles) != '0) |-> issue_hold);

  // R6: hold only while awake
  p_hold_awake_r6: assert property (@(posedge clk) disable iff (rst)
    issue_hold |-> cke);

endmodule

bind pdn_ctrl pdn_ctrl_chk #(.PD_W(PD_W), .XP_W(XP_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .pd_enable      (pd_enable),
  .cmd_fifo_empty (cmd_fifo_empty),
  .pd_period      (pd_period),
  .txp_cycles     (txp_cycles),
  .cke            (cke),
  .pwr_down       (pwr_down),
  .issue_hold     (issue_hold)
);

// File: tb/test_pdn_ctrl.sv
`timescale 1ns/1ps
module test_pdn_ctrl;

  localparam int PD_W = 8;
  localparam int XP_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_enable = 1'b1;
  logic cmd_fifo_empty = 1'b1;
  logic cmd_delay_done = 1'b1;
  logic rdata_fifo_empty = 1'b1;
  logic [PD_W-1:0] pd_period = '0;
  logic [XP_W-1:0] txp_cycles = '0;
  logic cke, pwr_down, issue_hold;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pdn_ctrl #(.PD_W(PD_W), .XP_W(XP_W)) i_pdn_ctrl (
    .clk(clk), .rst(rst), .pd_enable(pd_enable),
    .cmd_fifo_empty(cmd_fifo_empty), .cmd_delay_done(cmd_delay_done),
    .rdata_fifo_empty(rdata_fifo_empty), .pd_period(pd_period),
    .txp_cycles(txp_cycles), .cke(cke), .pwr_down(pwr_down),
    .issue_hold(issue_hold)
  );

  // one rising edge, then sample after the following falling edge
  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_idle();
    cmd_fifo_empty = 1'b1; cmd_delay_done = 1'b1; rdata_fifo_empty = 1'b1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    set_idle();
    step(); step();
    chk("R1 cke", cke, 1'b1);
    chk("R1 pwr_down", pwr_down, 1'b0);
    chk("R1 issue_hold", issue_hold, 1'b0);
    rst = 1'b0;
  endtask

  // waits n idle edges, expects entry exactly on the last one
  task automatic expect_entry(input string tag, input int p);
    for (int n = 1; n <= p; n++) begin
      step();
      chk(tag, cke, (n >= p) ? 1'b0 : 1'b1);
      chk("R7 mirror", pwr_down, ~cke);
    end
  endtask

  initial begin
    // sweep period and exit time
    for (int p = 0; p <= 5; p++) begin
      for (int x = 0; x <= 4; x++) begin
        pd_period = PD_W'(p);
        txp_cycles = XP_W'(x);
        pd_enable = 1'b1;
        do_reset();
        if (p == 0) begin
          for (int n = 0; n < 12; n++) begin
            step();
            chk("R4 period zero", cke, 1'b1);
          end
        end else begin
          expect_entry("R2 entry", p);
          // R9: other idle inputs do not wake
          cmd_delay_done = 1'b0; rdata_fifo_empty = 1'b0;
          for (int n = 0; n < 3; n++) begin
            step();
            chk("R9 no wake", cke, 1'b0);
          end
          set_idle();
          cmd_fifo_empty = 1'b0;
          for (int m = 1; m <= x + 2; m++) begin
            step();
            chk("R5 wake", cke, 1'b1);
            chk("R7 mirror", pwr_down, 1'b0);
            chk("R6 hold", issue_hold, (m <= x) ? 1'b1 : 1'b0);
          end
          for (int n = 0; n < p + 3; n++) begin
            step();
            chk("R8 busy awake", cke, 1'b1);
          end
          cmd_fifo_empty = 1'b1;
          expect_entry("R2 re-entry", p);
        end
      end
    end

    // R3: each idle input on its own restarts the count
    pd_period = PD_W'(4);
    txp_cycles = XP_W'(1);
    for (int which = 0; which < 3; which++) begin
      do_reset();
      for (int n = 0; n < 3; n++) begin
        step();
        chk("R3 pre", cke, 1'b1);
      end
      if (which == 0) cmd_fifo_empty = 1'b0;
      if (which == 1) cmd_delay_done = 1'b0;
      if (which == 2) rdata_fifo_empty = 1'b0;
      step();
      chk("R3 break", cke, 1'b1);
      set_idle();
      expect_entry("R3 restart", 4);
    end

    // R4: enable low blocks entry, then counts afresh
    pd_period = PD_W'(3);
    pd_enable = 1'b0;
    do_reset();
    for (int n = 0; n < 10; n++) begin
      step();
      chk("R4 disabled", cke, 1'b1);
    end
    pd_enable = 1'b1;
    expect_entry("R4 enabled", 3);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule